// File: doc/BRIEF.md
# Masked Register Bank

A bank of byte-wide registers mapped into a bounded window of a data address space. Each register is placed by a local address, and a bank-wide base offset is added to it to form the address the bus sees. The window is fixed by an inclusive lower and upper address, so a register is reachable only when its offset address lies inside that range.

Every register carries a reset value and a write mask, both fixed at elaboration. A write with a mask of all zeros is refused outright and the register keeps its contents. Any other mask acts as a filter: bits where the mask is 0 are stored as 0, and the remaining bits take the written data. Reads are combinational from the address and return 0x00 wherever no register is decoded.

The bank is reached by a plain synchronous bus made of an address, write data, a write strobe and read data. Writes take effect on the rising clock edge. A synchronous active-high reset reloads every register.

Top module: `masked_regbank`

## Requirements
- R1: While `rst` is high at a rising edge, every register loads its own reset value. Defaults: 0x20=0x00, 0x21=0xA5, 0x22=0x3C, 0x24=0x00, 0x2F=0x81.
- R2: A write to a register whose mask is 0xFF (default 0x20) stores the written byte unchanged.
- R3: A write to a register with a nonzero partial mask stores `wdata & mask`, so bits where the mask is 0 are stored as 0. Defaults: mask 0x0F at 0x21 and mask 0xF0 at 0x24.
- R4: A write to a register whose mask is 0x00 (default 0x22) leaves it unchanged.
- R5: A register's bus address is its local address plus the bank offset (default offset 0x20, locals 0x00, 0x01, 0x02, 0x04, 0x0F). A write to a bare local address does not reach the register.
- R6: The window is inclusive at both ends (defaults 0x20 to 0x2F). A register whose offset address is 0x30 lies outside the window: reads there return 0x00 and writes there have no effect.
- R7: A write to any address outside the window changes no register.
- R8: An address inside the window that matches no register reads 0x00, and writing it changes no register.
- R9: Read data follows the address combinationally. A write becomes visible only after the rising edge on which `bus_we` is high, and no register changes while `bus_we` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (8) | Read and write address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_rdata | output | 8 | Combinational read data |

## Verification
The assertions assume that the configured registers have distinct offset addresses and that every input is at a known level at each rising edge. They also assume that `rst` is high at the first edge, so the reset check has a defined starting point. The bench starts with reset high, changes the bus only at falling edges, and never leaves an input undriven. The default configuration it uses contains no two registers at the same address.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // Next stored value after a write attempt under a mask
  function automatic byte_t mask_write(byte_t cur, byte_t wdata, byte_t mask);
    if (mask == '0) return cur;
    return wdata & mask;
  endfunction

  // True when addr selects a register at local+offset inside [lo, hi]
  function automatic logic addr_hit(logic [15:0] addr, logic [15:0] loc,
                                    logic [15:0] ofs, logic [15:0] lo,
                                    logic [15:0] hi, int aw);
    logic [15:0] full;
    logic [15:0] amask;
    amask = (16'h1 << aw) - 16'h1;
    full  = (loc + ofs) & amask;
    return (addr == full) && (full >= lo) && (full <= hi);
  endfunction
endpackage

// File: rtl/regbank_decoder.sv
module regbank_decoder
  import regbank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_REGS = 6,
  parameter logic [ADDR_W-1:0] WIN_LO = '0,
  parameter logic [ADDR_W-1:0] WIN_HI = '1,
  parameter logic [ADDR_W-1:0] BASE_OFS = '0,
  parameter logic [NUM_REGS-1:0][ADDR_W-1:0] LOC_ADDR = '0
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_REGS-1:0] hit,
  output logic                in_window
);
  assign in_window = (addr >= WIN_LO) && (addr <= WIN_HI);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    assign hit[i] = addr_hit(16'(addr), 16'(LOC_ADDR[i]), 16'(BASE_OFS),
                             16'(WIN_LO), 16'(WIN_HI), ADDR_W);
  end
endmodule

// File: rtl/regbank_cell.sv
module regbank_cell
  import regbank_pkg::*;
#(
  parameter byte_t RST_VAL = '0,
  parameter byte_t WR_MASK = '1
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_en,
  input  byte_t wdata,
  output byte_t q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= RST_VAL;
    else if (wr_en) q <= mask_write(q, wdata, WR_MASK);
  end
endmodule

// File: rtl/regbank_readmux.sv
module regbank_readmux
  import regbank_pkg::*;
#(
  parameter int NUM_REGS = 6
) (
  input  logic [NUM_REGS-1:0]         hit,
  input  logic [NUM_REGS-1:0][BYTE_W-1:0] store,
  output byte_t                       rdata
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (hit[i]) rdata = rdata | store[i];
  end
endmodule

// File: rtl/masked_regbank.sv
module masked_regbank
  import regbank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_REGS = 6,
  parameter logic [ADDR_W-1:0] WIN_LO = 8'h20,
  parameter logic [ADDR_W-1:0] WIN_HI = 8'h2F,
  parameter logic [ADDR_W-1:0] BASE_OFS = 8'h20,
  parameter logic [NUM_REGS-1:0][ADDR_W-1:0] LOC_ADDR =
    {8'h10, 8'h0F, 8'h04, 8'h02, 8'h01, 8'h00},
  parameter logic [NUM_REGS-1:0][7:0] RST_VALS =
    {8'h7F, 8'h81, 8'h00, 8'h3C, 8'hA5, 8'h00},
  parameter logic [NUM_REGS-1:0][7:0] WR_MASKS =
    {8'hFF, 8'hFF, 8'hF0, 8'h00, 8'h0F, 8'hFF}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  output logic [7:0]        bus_rdata
);
  // Named internal events for the checker
  logic [NUM_REGS-1:0]            reg_hit;
  logic                           addr_in_window;
  logic [NUM_REGS-1:0]            reg_wr;
  logic [NUM_REGS-1:0][BYTE_W-1:0] reg_store;

  regbank_decoder #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI),
    .BASE_OFS(BASE_OFS), .LOC_ADDR(LOC_ADDR)
  ) u_dec (
    .addr(bus_addr), .hit(reg_hit), .in_window(addr_in_window)
  );

  assign reg_wr = reg_hit & {NUM_REGS{bus_we}};

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    regbank_cell #(.RST_VAL(RST_VALS[i]), .WR_MASK(WR_MASKS[i])) u_cell (
      .clk(clk), .rst(rst), .wr_en(reg_wr[i]), .wdata(bus_wdata),
      .q(reg_store[i])
    );
  end

  regbank_readmux #(.NUM_REGS(NUM_REGS)) u_rmux (
    .hit(reg_hit), .store(reg_store), .rdata(bus_rdata)
  );
endmodule

// File: rtl/masked_regbank_chk.sv
module masked_regbank_chk #(
  parameter int NUM_REGS = 6,
  parameter logic [NUM_REGS-1:0][7:0] RST_VALS = '0,
  parameter logic [NUM_REGS-1:0][7:0] WR_MASKS = '1
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      bus_we,
  input logic [7:0]                bus_wdata,
  input logic [7:0]                bus_rdata,
  input logic [NUM_REGS-1:0]       reg_hit,
  input logic                      addr_in_window,
  input logic [NUM_REGS-1:0][7:0]  reg_store
);
  // R1: reset reloads every register
  assert_reset_load_R1: assert property (@(posedge clk)
    rst |=> (reg_store == RST_VALS));

  // R5/R6: at most one register decoded, and only inside the window
  assert_single_hit_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(reg_hit));
  assert_hit_in_window_R6: assert property (@(posedge clk) disable iff (rst)
    (|reg_hit) |-> addr_in_window);

  // R7: a write outside the window changes nothing
  assert_outside_write_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !addr_in_window) |=> $stable(reg_store));

  // R8: undecoded address reads zero
  assert_empty_read_R8: assert property (@(posedge clk) disable iff (rst)
    !(|reg_hit) |-> (bus_rdata == 8'h00));

  // R9: no register moves without a write strobe
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> $stable(reg_store));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
    if (WR_MASKS[i] == 8'h00) begin : g_prot
      // R4: a protected register never changes
      assert_protected_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(reg_store[i]));
    end else begin : g_filt
      // R2/R3: written value is filtered by the mask
      assert_masked_write_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && reg_hit[i]) |=> (reg_store[i] == ($past(bus_wdata) & WR_MASKS[i])));
    end
  end
endmodule

bind masked_regbank masked_regbank_chk #(
  .NUM_REGS(NUM_REGS), .RST_VALS(RST_VALS), .WR_MASKS(WR_MASKS)
) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .reg_hit(reg_hit), .addr_in_window(addr_in_window),
  .reg_store(reg_store)
);

// File: tb/masked_regbank_tb.sv
module masked_regbank_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  masked_regbank dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata)
  );

  typedef struct packed {
    logic       we;
    logic [7:0] waddr;
    logic [7:0] wdata;
    logic [7:0] raddr;
    logic [7:0] exp;
    logic [7:0] req;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 8'h20, 8'h5A, 8'h20, 8'h5A, 8'd2}, // R2 full mask
    '{1'b1, 8'h21, 8'hFF, 8'h21, 8'h0F, 8'd3}, // R3 low nibble kept
    '{1'b1, 8'h24, 8'h3C, 8'h24, 8'h30, 8'd3}, // R3 high nibble kept
    '{1'b1, 8'h22, 8'hFF, 8'h22, 8'h3C, 8'd4}, // R4 protected
    '{1'b1, 8'h2F, 8'hC3, 8'h2F, 8'hC3, 8'd6}, // R6 upper bound decoded
    '{1'b1, 8'h30, 8'h11, 8'h30, 8'h00, 8'd6}, // R6 register past window
    '{1'b1, 8'h1F, 8'h22, 8'h20, 8'h5A, 8'd7}, // R7 below window
    '{1'b1, 8'h10, 8'hEE, 8'h21, 8'h0F, 8'd7}, // R7 far below window
    '{1'b1, 8'h23, 8'h99, 8'h23, 8'h00, 8'd8}, // R8 hole reads zero
    '{1'b1, 8'h25, 8'h77, 8'h24, 8'h30, 8'd8}, // R8 hole write ignored
    '{1'b0, 8'h20, 8'hFF, 8'h20, 8'h5A, 8'd9}, // R9 no strobe
    '{1'b1, 8'h21, 8'h30, 8'h21, 8'h00, 8'd3}, // R3 all bits masked off
    '{1'b1, 8'h00, 8'h44, 8'h20, 8'h5A, 8'd5}, // R5 bare local address
    '{1'b1, 8'h04, 8'hF0, 8'h24, 8'h30, 8'd5}  // R5 bare local address
  };

  task automatic check(input logic [7:0] act, input logic [7:0] exp,
                       input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic read_at(input logic [7:0] a, input logic [7:0] exp,
                         input string req);
    bus_addr = a;
    #1;
    check(bus_rdata, exp, req);
  endtask

  task automatic check_reset_vals(input string req);
    read_at(8'h20, 8'h00, req);
    read_at(8'h21, 8'hA5, req);
    read_at(8'h22, 8'h3C, req);
    read_at(8'h24, 8'h00, req);
    read_at(8'h2F, 8'h81, req);
    read_at(8'h30, 8'h00, req);
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_reset_vals("R1");

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      bus_addr  = VECS[i].waddr;
      bus_wdata = VECS[i].wdata;
      bus_we    = VECS[i].we;
      @(negedge clk);
      bus_we = 1'b0;
      read_at(VECS[i].raddr, VECS[i].exp, $sformatf("R%0d", VECS[i].req));
    end

    // R9: read follows address without a clock, write waits for the edge
    @(negedge clk);
    read_at(8'h2F, 8'hC3, "R9");
    read_at(8'h20, 8'h5A, "R9");
    bus_wdata = 8'h11;
    bus_we = 1'b1;
    #1;
    check(bus_rdata, 8'h5A, "R9");
    @(negedge clk);
    bus_we = 1'b0;
    #1;
    check(bus_rdata, 8'h11, "R9");

    // R1: reset in the middle of operation restores every register
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_reset_vals("R1");

    // R2: lower window bound takes a second pattern
    @(negedge clk);
    bus_addr = 8'h20;
    bus_wdata = 8'hFF;
    bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    read_at(8'h20, 8'hFF, "R2");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule